// File: doc/BRIEF.md
# Tower patch sum and high-tower extractor

This block condenses sixteen tower energies into one trigger patch. Each tower arrives as a 10-bit value, the upper part of a 12-bit digitized sample. Only the upper eight bits of each tower go into the patch sum. The 12-bit sum is compressed to a 6-bit patch code by a lookup table held in registers, and software-style loading of that table uses a plain address/data/write-enable port.

In parallel, the block finds the largest of the sixteen towers and cuts a 6-bit window out of it. The window position is chosen per sample. The window's top bit saturates: it reads 1 whenever that bit or any bit above it in the tower is 1. The output is the pair of 6-bit codes (patch code and high-tower code) qualified by a valid strobe, three clock cycles after the input sample.

The table is indexed by the upper ten bits of the 12-bit sum. This gives 1024 entries, each covering four adjacent sums.

Top module: `tpatch_top`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_out, patch_code and ht_code are all 0.
- R2: valid_out equals valid_in delayed by exactly three clock cycles; the codes that go with a sample appear in the cycle its valid_out is high.
- R3: Only bits [9:2] of each tower enter the patch sum, so bits [1:0] of a tower never change patch_code.
- R4: patch_code equals the table entry addressed by bits [11:2] of the sum of the sixteen 8-bit tower fields.
- R5: After reset, table entry i holds i >> 4, so the patch code equals bits [11:6] of the sum until the table is written.
- R6: When lut_we is high at a clock edge, the entry at lut_addr takes lut_data; every sample entering afterwards uses the new value.
- R7: The high tower is the largest of the sixteen full 10-bit tower values; tower j occupies towers_in[10j+9:10j].
- R8: With window offset o, ht_code[4:0] equals bits [o+4:o] of the high tower.
- R9: ht_code[5] is 1 exactly when any bit from o+5 to 9 of the high tower is 1.
- R10: A win_off value above 4 acts as offset 4.
- R11: win_off is captured together with the towers, so each sample uses its own offset even when offsets change every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Marks towers_in and win_off as a sample |
| towers_in | input | 160 | Sixteen 10-bit towers, tower j at bits [10j+9:10j] |
| win_off | input | 3 | High-tower window offset; values above 4 clamp to 4 |
| lut_we | input | 1 | Table write enable |
| lut_addr | input | 10 | Table entry to write |
| lut_data | input | 6 | Code written into the table |
| valid_out | output | 1 | Marks the output code pair |
| patch_code | output | 6 | Table-compressed patch energy |
| ht_code | output | 6 | Saturated window of the largest tower |

## Verification
The hardest states to reach from the ports are the two ends of the sum range and the saturation of the window. Uniform random towers sum near the middle and almost never reach the top table entries. A random largest tower seldom has set bits just above a low window while the window bits themselves are small.

The stimulus therefore mixes several tower shapes with the uniform draws:
- all towers near full scale;
- one dominant tower with a single high bit;
- all towers carrying only their two discarded low bits.

Offsets are drawn from the whole 3-bit range so that the clamped values occur often. Table writes are placed at the extreme indices that the directed full-scale and all-zero samples then read back.

// File: rtl/tpatch_pkg.sv
package tpatch_pkg;
    localparam int TP_NTOW   = 16;
    localparam int TP_TW     = 10;
    localparam int TP_SUMB   = 8;
    localparam int TP_CODE_W = 6;
    localparam int TP_OFF_W  = 3;
    localparam int TP_LUT_AW = 10;
endpackage

// File: rtl/tpatch_sum.sv
module tpatch_sum #(
    parameter int NTOW  = 16,
    parameter int TW    = 10,
    parameter int SUMB  = 8,
    parameter int SUM_W = 12
) (
    input  logic [NTOW*TW-1:0] towers,
    output logic [SUM_W-1:0]   sum
);
    localparam int NODES = 2*NTOW - 1;
    localparam int DROP  = TW - SUMB;

    logic [NTOW-1:0] lo_unused_bits;

    // heap-ordered adder tree: node i adds nodes 2i+1 and 2i+2
    for (genvar i = 0; i < NODES; i++) begin : g_node
        logic [SUM_W-1:0] v;
        if (i < NTOW-1) begin : g_add
            assign v = g_node[2*i+1].v + g_node[2*i+2].v;
        end else begin : g_leaf
            assign v = SUM_W'(towers[(i-(NTOW-1))*TW + DROP +: SUMB]);
            assign lo_unused_bits[i-(NTOW-1)] = ^towers[(i-(NTOW-1))*TW +: DROP];
        end
    end

    assign sum = g_node[0].v;
endmodule

// File: rtl/tpatch_max.sv
module tpatch_max #(
    parameter int NTOW = 16,
    parameter int TW   = 10
) (
    input  logic [NTOW*TW-1:0] towers,
    output logic [TW-1:0]      max_val
);
    localparam int NODES = 2*NTOW - 1;

    // heap-ordered comparator tree
    for (genvar i = 0; i < NODES; i++) begin : g_node
        logic [TW-1:0] v;
        if (i < NTOW-1) begin : g_cmp
            assign v = (g_node[2*i+1].v >= g_node[2*i+2].v) ?
                       g_node[2*i+1].v : g_node[2*i+2].v;
        end else begin : g_leaf
            assign v = towers[(i-(NTOW-1))*TW +: TW];
        end
    end

    assign max_val = g_node[0].v;
endmodule

// File: rtl/tpatch_lut.sv
module tpatch_lut #(
    parameter int AW = 10,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [CW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int SH    = AW - CW;

    logic [CW-1:0] mem_q [DEPTH];
    logic [CW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    // reset contents: truncation of the index to its top CW bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= CW'(i >> SH);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tpatch_window.sv
module tpatch_window #(
    parameter int TW     = 10,
    parameter int CODE_W = 6,
    parameter int OFF_W  = 3
) (
    input  logic [TW-1:0]     tower,
    input  logic [OFF_W-1:0]  off,
    output logic [CODE_W-1:0] code
);
    localparam int MAX_OFF = TW - CODE_W;

    logic [OFF_W-1:0] off_c;
    logic [TW-1:0]    sh;

    always_comb begin
        off_c = (off > OFF_W'(MAX_OFF)) ? OFF_W'(MAX_OFF) : off;
        sh    = tower >> off_c;
        // top code bit absorbs every tower bit at or above its position
        code  = {|sh[TW-1:CODE_W-1], sh[CODE_W-2:0]};
    end
endmodule

// File: rtl/tpatch_top.sv
module tpatch_top
    import tpatch_pkg::*;
#(
    parameter int NTOW   = TP_NTOW,
    parameter int TW     = TP_TW,
    parameter int SUMB   = TP_SUMB,
    parameter int CODE_W = TP_CODE_W,
    parameter int OFF_W  = TP_OFF_W,
    parameter int LUT_AW = TP_LUT_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic [NTOW*TW-1:0]   towers_in,
    input  logic [OFF_W-1:0]     win_off,
    input  logic                 lut_we,
    input  logic [LUT_AW-1:0]    lut_addr,
    input  logic [CODE_W-1:0]    lut_data,
    output logic                 valid_out,
    output logic [CODE_W-1:0]    patch_code,
    output logic [CODE_W-1:0]    ht_code
);
    localparam int SUM_W = SUMB + $clog2(NTOW);
    localparam int LOW_W = SUM_W - LUT_AW;

    typedef struct packed {
        logic                s1_v;
        logic [NTOW*TW-1:0]  s1_tw;
        logic [OFF_W-1:0]    s1_off;
        logic                s2_v;
        logic [LUT_AW-1:0]   s2_idx;
        logic [TW-1:0]       s2_max;
        logic [OFF_W-1:0]    s2_off;
        logic                s3_v;
        logic [CODE_W-1:0]   s3_patch;
        logic [CODE_W-1:0]   s3_ht;
    } pipe_t;

    pipe_t q, d;

    logic [SUM_W-1:0]  sum_w;
    logic [TW-1:0]     max_w;
    logic [CODE_W-1:0] lut_rd;
    logic [CODE_W-1:0] win_code;

    tpatch_sum #(.NTOW(NTOW), .TW(TW), .SUMB(SUMB), .SUM_W(SUM_W)) u_sum (
        .towers (q.s1_tw),
        .sum    (sum_w)
    );

    tpatch_max #(.NTOW(NTOW), .TW(TW)) u_max (
        .towers  (q.s1_tw),
        .max_val (max_w)
    );

    tpatch_lut #(.AW(LUT_AW), .CW(CODE_W)) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lut_we),
        .waddr (lut_addr),
        .wdata (lut_data),
        .raddr (q.s2_idx),
        .rdata (lut_rd)
    );

    tpatch_window #(.TW(TW), .CODE_W(CODE_W), .OFF_W(OFF_W)) u_win (
        .tower (q.s2_max),
        .off   (q.s2_off),
        .code  (win_code)
    );

    if (LOW_W > 0) begin : g_sum_low
        logic sum_low_unused;
        assign sum_low_unused = ^sum_w[LOW_W-1:0];
    end

    always_comb begin
        d          = q;
        // stage 1: capture the sample and its window offset
        d.s1_v     = valid_in;
        d.s1_tw    = towers_in;
        d.s1_off   = win_off;
        // stage 2: tree sum (table index) and largest tower
        d.s2_v     = q.s1_v;
        d.s2_idx   = sum_w[SUM_W-1 -: LUT_AW];
        d.s2_max   = max_w;
        d.s2_off   = q.s1_off;
        // stage 3: table lookup and windowing
        d.s3_v     = q.s2_v;
        d.s3_patch = lut_rd;
        d.s3_ht    = win_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_out  = q.s3_v;
    assign patch_code = q.s3_patch;
    assign ht_code    = q.s3_ht;
endmodule

// File: rtl/tpatch_chk.sv
module tpatch_chk #(
    parameter int NTOW   = 16,
    parameter int TW     = 10,
    parameter int CODE_W = 6,
    parameter int OFF_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_in,
    input logic                valid_out,
    input logic [CODE_W-1:0]   ht_code,
    input logic [NTOW*TW-1:0]  s1_tw,
    input logic [TW-1:0]       s2_max,
    input logic [OFF_W-1:0]    s2_off
);
    localparam int MAX_OFF = TW - CODE_W;

    logic [2:0]        vsr;
    logic [TW-1:0]     max_c, ref_max;
    logic [CODE_W-2:0] low_c, ref_low;
    logic              top_c, ref_top;
    int                oc;

    always_comb begin
        max_c = '0;
        for (int j = 0; j < NTOW; j++) begin
            if (s1_tw[j*TW +: TW] > max_c) begin
                max_c = s1_tw[j*TW +: TW];
            end
        end
        oc = (int'(s2_off) > MAX_OFF) ? MAX_OFF : int'(s2_off);
        for (int k = 0; k < CODE_W-1; k++) begin
            low_c[k] = s2_max[oc+k];
        end
        top_c = 1'b0;
        for (int i = 0; i < TW; i++) begin
            if (i >= oc + CODE_W - 1 && s2_max[i]) begin
                top_c = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsr     <= '0;
            ref_max <= '0;
            ref_low <= '0;
            ref_top <= 1'b0;
        end else begin
            vsr     <= {vsr[1:0], valid_in};
            ref_max <= max_c;
            ref_low <= low_c;
            ref_top <= top_c;
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == vsr[2]);

    // R7
    max_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_max == ref_max);

    // R8
    win_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ht_code[CODE_W-2:0] == ref_low);

    // R9
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ht_code[CODE_W-1] == ref_top);
endmodule

bind tpatch_top tpatch_chk #(
    .NTOW(NTOW), .TW(TW), .CODE_W(CODE_W), .OFF_W(OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .valid_out (valid_out),
    .ht_code   (ht_code),
    .s1_tw     (q.s1_tw),
    .s2_max    (q.s2_max),
    .s2_off    (q.s2_off)
);

// File: tb/tpatch_top_test.sv
module tpatch_top_test;
    localparam int NTOW = 16;
    localparam int TW   = 10;
    localparam int CW   = 6;
    localparam int OW   = 3;
    localparam int AW   = 10;
    localparam int VW   = NTOW*TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [VW-1:0] towers_in = '0;
    logic [OW-1:0] win_off = '0;
    logic          lut_we = 1'b0;
    logic [AW-1:0] lut_addr = '0;
    logic [CW-1:0] lut_data = '0;
    logic          valid_out;
    logic [CW-1:0] patch_code;
    logic [CW-1:0] ht_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [CW-1:0] lut_m [1<<AW];
    logic          hv [3];
    logic [CW-1:0] hp [3];
    logic [CW-1:0] hh [3];
    string         htag [3];

    always #10 clk = ~clk;

    tpatch_top uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .towers_in(towers_in),
        .win_off(win_off), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_data(lut_data), .valid_out(valid_out), .patch_code(patch_code),
        .ht_code(ht_code)
    );

    function automatic logic [11:0] f_sum(input logic [VW-1:0] t);
        logic [11:0] s = '0;
        for (int j = 0; j < NTOW; j++) s += 12'(t[j*TW+2 +: 8]);
        return s;
    endfunction

    function automatic logic [TW-1:0] f_max(input logic [VW-1:0] t);
        logic [TW-1:0] m = '0;
        for (int j = 0; j < NTOW; j++) if (t[j*TW +: TW] > m) m = t[j*TW +: TW];
        return m;
    endfunction

    function automatic logic [CW-1:0] f_ht(input logic [TW-1:0] m, input logic [OW-1:0] off);
        int o;
        logic [CW-1:0] c = '0;
        o = (off > 3'd4) ? 4 : int'(off);
        for (int k = 0; k < 5; k++) c[k] = m[o+k];
        for (int i = 0; i < TW; i++) if (i >= o+5 && m[i]) c[5] = 1'b1;
        return c;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [VW-1:0] t, input logic [OW-1:0] o,
                        input logic we, input logic [AW-1:0] a, input logic [CW-1:0] dd,
                        input string tag);
        @(negedge clk);
        check("R2", "valid_out", 8'(valid_out), 8'(hv[2]));
        if (hv[2]) begin
            check(htag[2], "patch_code", 8'(patch_code), 8'(hp[2]));
            check(htag[2], "ht_code", 8'(ht_code), 8'(hh[2]));
        end
        if (we) lut_m[a] = dd;
        for (int i = 2; i > 0; i--) begin
            hv[i] = hv[i-1]; hp[i] = hp[i-1]; hh[i] = hh[i-1]; htag[i] = htag[i-1];
        end
        hv[0]   = v;
        hp[0]   = lut_m[f_sum(t) >> 2];
        hh[0]   = f_ht(f_max(t), o);
        htag[0] = tag;
        valid_in  = v;
        towers_in = t;
        win_off   = o;
        lut_we    = we;
        lut_addr  = a;
        lut_data  = dd;
    endtask

    task automatic sample(input logic [VW-1:0] t, input logic [OW-1:0] o, input string tag);
        step(1'b1, t, o, 1'b0, '0, '0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, '0, '0, "R2 idle");
    endtask

    task automatic lut_write(input logic [AW-1:0] a, input logic [CW-1:0] dd);
        step(1'b0, '0, '0, 1'b1, a, dd, "R6 write");
    endtask

    function automatic logic [VW-1:0] fill(input logic [TW-1:0] val);
        logic [VW-1:0] t;
        for (int j = 0; j < NTOW; j++) t[j*TW +: TW] = val;
        return t;
    endfunction

    function automatic logic [VW-1:0] rand_towers();
        logic [VW-1:0] t = '0;
        int mode;
        mode = int'($urandom_range(0, 3));
        for (int j = 0; j < NTOW; j++) begin
            case (mode)
                0: t[j*TW +: TW] = TW'($urandom_range(0, 1023));
                1: t[j*TW +: TW] = TW'($urandom_range(900, 1023));
                2: t[j*TW +: TW] = TW'($urandom_range(0, 31));
                default: t[j*TW +: TW] = TW'($urandom_range(0, 3));
            endcase
        end
        if (mode >= 2) begin
            t[int'($urandom_range(0, NTOW-1))*TW +: TW] = TW'(1 << $urandom_range(0, 9));
        end
        return t;
    endfunction

    task automatic random_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 4) == 0) idle(1);
            else sample(rand_towers(), OW'($urandom_range(0, 7)), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] t;
        void'($urandom(32'd20250607));
        for (int i = 0; i < (1<<AW); i++) lut_m[i] = CW'(i >> 4);
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; hp[i] = '0; hh[i] = '0; htag[i] = "none";
        end

        repeat (4) @(negedge clk);
        check("R1", "valid_out in reset", 8'(valid_out), 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid_out", 8'(valid_out), 8'h0);
        check("R1", "patch_code", 8'(patch_code), 8'h0);
        check("R1", "ht_code", 8'(ht_code), 8'h0);

        // directed corners
        sample('0, 3'd0, "R5 zero");
        sample(fill(10'h3FF), 3'd0, "R5 R9 full scale off0");
        sample(fill(10'h3FF), 3'd4, "R8 full scale off4");
        sample(fill(10'h003), 3'd0, "R3 low bits only");
        t = '0; t[5*TW +: TW] = 10'h040;
        sample(t, 3'd0, "R9 saturation off0");
        sample(t, 3'd1, "R9 R11 saturation off1");
        sample(t, 3'd2, "R8 R11 window off2");
        t = '0; t[15*TW +: TW] = 10'h2AB; t[3*TW +: TW] = 10'h2AA;
        sample(t, 3'd4, "R7 R8 off4");
        sample(t, 3'd5, "R10 clamp 5");
        sample(t, 3'd6, "R10 clamp 6");
        sample(t, 3'd7, "R10 clamp 7");
        t = '0; t[0] = 1'b1; t[TW +: TW] = 10'h001;
        sample(t, 3'd0, "R3 R7 discarded bits");
        idle(3);

        random_run(400, "R4 R5 R7 R8 R9 R11 random");
        idle(3);

        // table loading at the extreme indices, then random entries
        lut_write(10'd1020, 6'd5);
        lut_write(10'd0, 6'd42);
        for (int i = 0; i < 40; i++) lut_write(AW'($urandom_range(0, 1023)), CW'($urandom_range(0, 63)));
        sample(fill(10'h3FF), 3'd3, "R6 written top entry");
        sample('0, 3'd0, "R6 written zero entry");
        sample(fill(10'h003), 3'd0, "R3 R6 low bits only");
        idle(3);

        random_run(400, "R4 R6 R7 R8 R9 R10 random");
        idle(4);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule